// File: doc/BRIEF.md
# Fully Associative Miss Line Cache

This block is a small fully associative line store that sits next to a direct-mapped first-level cache. Each access to the first-level cache is also presented here as a probe with the same line address. All entries compare their tags against that address at once. One cycle later the block answers with a registered hit flag and, on a hit, the stored line. The requester can then reload its direct-mapped array from this line and avoid a trip to the next level.

When both caches miss, the line that comes back from the next level is written into the first-level cache and, through the fill port, into this block as well. The fill goes into the lowest-numbered invalid entry if one exists. Otherwise it replaces the least recently used entry. Recency is kept as one age counter per entry: age 0 is the most recently used entry and age ENTRIES-1 the least. A probe hit and a fill each make their entry the most recently used. A fill whose address is already present overwrites that entry in place, so no duplicate entry is made. A flush input empties the store.

The response path is a three-state machine. IDLE is entered from any state when no probe is presented. HIT is entered when a probe matches a valid entry. MISS is entered when a probe matches nothing, or when the probe arrives in a flush cycle. The output process decodes the state: IDLE drives no response, HIT drives the captured line, and MISS drives a zero line.

Top module: `miss_line_cache`

## Requirements
- R1: After reset the response valid output is low and every probe misses until a fill is made.
- R2: A probe presented in cycle t produces rsp_valid_o high in cycle t+1, and a cycle with no probe produces rsp_valid_o low in the next cycle.
- R3: A probe whose line address matches a valid entry, in any entry position, returns rsp_hit_o high and that entry's 128-bit line on rsp_data_o.
- R4: A probe that matches no valid entry returns rsp_hit_o low with rsp_data_o equal to zero.
- R5: Filling ENTRIES distinct lines into an empty store keeps all of them, so each one hits afterwards.
- R6: A fill into a full store evicts the least recently used line, and a probe hit counts as a use.
- R7: A fill whose address is already stored replaces that line's data and makes it most recently used, without taking a second entry.
- R8: Flush invalidates every entry. A fill in the flush cycle is dropped, and a probe in the flush cycle reports a miss.
- R9: When a probe and a fill occur in the same cycle, the probe sees the contents from before the fill. The probe-hit entry is marked used first, then the filled entry becomes the most recently used, and the victim is chosen after the probe's update.
- R10: rsp_hit_o is never high while rsp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| probe_valid_i | input | 1 | Probe request this cycle |
| probe_addr_i | input | ADDR_W | Line address being probed |
| rsp_valid_o | output | 1 | Probe answer, one cycle after the probe |
| rsp_hit_o | output | 1 | Probe answer is a hit |
| rsp_data_o | output | LINE_W | Line returned on a hit, zero otherwise |
| fill_valid_i | input | 1 | Write a line returned by the next level |
| fill_addr_i | input | ADDR_W | Line address of the fill |
| fill_data_i | input | LINE_W | Line data of the fill |

## Verification
A probe and a fill can land in the same cycle. The probe may hit the entry that the fill would otherwise evict, or it may carry the very address being refilled. The bench issues both requests on one clock edge. It then checks that the probe answer carries the line as it was before the fill. Follow-up probes show that the line hit in that cycle survives, that the next-oldest line is evicted, and that a same-address fill leaves one updated copy.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/mlc_store.sv
module mlc_store #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 28,
    parameter int LINE_W  = 128,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [ADDR_W-1:0]  wr_tag_i,
    input  logic [LINE_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  prb_tag_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [LINE_W-1:0]  rd_data_o,
    output logic [ENTRIES-1:0] vld_o,
    output logic [ENTRIES-1:0] prb_hit_o,
    output logic [ENTRIES-1:0] fil_hit_o
);

    logic [ADDR_W-1:0] tag_q  [ENTRIES];
    logic [LINE_W-1:0] data_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic sel;
        assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                vld_o[g] <= 1'b0;
            end else if (sel) begin
                vld_o[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[g]  <= wr_tag_i;
                data_q[g] <= wr_data_i;
            end
        end

        assign prb_hit_o[g] = vld_o[g] && (tag_q[g] == prb_tag_i);
        assign fil_hit_o[g] = vld_o[g] && (tag_q[g] == wr_tag_i);
    end

    assign rd_data_o = data_q[rd_idx_i];

endmodule

// File: rtl/mlc_age.sv
module mlc_age #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               t0_en_i,
    input  logic [IDX_W-1:0]   t0_idx_i,
    input  logic               t1_en_i,
    input  logic [IDX_W-1:0]   t1_idx_i,
    input  logic [ENTRIES-1:0] vld_i,
    output logic [IDX_W-1:0]   victim_o
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [IDX_W-1:0] mid   [ENTRIES];
    logic [IDX_W-1:0] nxt   [ENTRIES];

    // first touch: probe hit
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            mid[i] = age_q[i];
            if (t0_en_i) begin
                if (IDX_W'(i) == t0_idx_i) begin
                    mid[i] = '0;
                end else if (age_q[i] < age_q[t0_idx_i]) begin
                    mid[i] = age_q[i] + 1'b1;
                end
            end
        end
    end

    // second touch: fill, applied on top of the first
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            nxt[i] = mid[i];
            if (t1_en_i) begin
                if (IDX_W'(i) == t1_idx_i) begin
                    nxt[i] = '0;
                end else if (mid[i] < mid[t1_idx_i]) begin
                    nxt[i] = mid[i] + 1'b1;
                end
            end
        end
    end

    // victim: lowest invalid entry, else the oldest after the probe touch
    always_comb begin
        logic found;
        found    = 1'b0;
        victim_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !vld_i[i]) begin
                victim_o = IDX_W'(i);
                found    = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (mid[i] == OLDEST) begin
                    victim_o = IDX_W'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n || clr_i) begin
                age_q[i] <= IDX_W'(i);
            end else begin
                age_q[i] <= nxt[i];
            end
        end
    end

endmodule

// File: rtl/mlc_rsp.sv
module mlc_rsp
    import mlc_pkg::*;
#(
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              probe_en_i,
    input  logic              hit_i,
    input  logic [LINE_W-1:0] data_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [LINE_W-1:0] rsp_data_o
);

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [LINE_W-1:0] line_q;

    always_comb begin
        if (!probe_en_i) begin
            state_d = RSP_IDLE;
        end else if (hit_i) begin
            state_d = RSP_HIT;
        end else begin
            state_d = RSP_MISS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            if (probe_en_i && hit_i) begin
                line_q <= data_i;
            end
        end
    end

    always_comb begin
        rsp_valid_o = 1'b0;
        rsp_hit_o   = 1'b0;
        rsp_data_o  = '0;
        unique case (state_q)
            RSP_IDLE: begin
                rsp_valid_o = 1'b0;
            end
            RSP_HIT: begin
                rsp_valid_o = 1'b1;
                rsp_hit_o   = 1'b1;
                rsp_data_o  = line_q;
            end
            RSP_MISS: begin
                rsp_valid_o = 1'b1;
            end
            default: begin
                rsp_valid_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/miss_line_cache.sv
module miss_line_cache #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 28,
    parameter int LINE_W  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              probe_valid_i,
    input  logic [ADDR_W-1:0] probe_addr_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [LINE_W-1:0] rsp_data_o,
    input  logic              fill_valid_i,
    input  logic [ADDR_W-1:0] fill_addr_i,
    input  logic [LINE_W-1:0] fill_data_i
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_vec;
    logic [ENTRIES-1:0] prb_vec;
    logic [ENTRIES-1:0] fil_vec;
    logic [IDX_W-1:0]   prb_idx;
    logic [IDX_W-1:0]   fil_idx;
    logic [IDX_W-1:0]   victim_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic               prb_any;
    logic               fil_any;
    logic               live_hit;
    logic               live_fill;
    logic [LINE_W-1:0]  rd_data;

    always_comb begin
        prb_idx = '0;
        fil_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (prb_vec[i]) prb_idx = IDX_W'(i);
            if (fil_vec[i]) fil_idx = IDX_W'(i);
        end
    end

    assign prb_any   = |prb_vec;
    assign fil_any   = |fil_vec;
    assign live_hit  = probe_valid_i && prb_any && !flush_i;
    assign live_fill = fill_valid_i && !flush_i;
    assign wr_idx    = fil_any ? fil_idx : victim_idx;

    mlc_store #(
        .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (flush_i),
        .wr_en_i   (live_fill),
        .wr_idx_i  (wr_idx),
        .wr_tag_i  (fill_addr_i),
        .wr_data_i (fill_data_i),
        .prb_tag_i (probe_addr_i),
        .rd_idx_i  (prb_idx),
        .rd_data_o (rd_data),
        .vld_o     (vld_vec),
        .prb_hit_o (prb_vec),
        .fil_hit_o (fil_vec)
    );

    mlc_age #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W)
    ) age_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (flush_i),
        .t0_en_i  (live_hit),
        .t0_idx_i (prb_idx),
        .t1_en_i  (live_fill),
        .t1_idx_i (wr_idx),
        .vld_i    (vld_vec),
        .victim_o (victim_idx)
    );

    mlc_rsp #(
        .LINE_W(LINE_W)
    ) rsp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .probe_en_i  (probe_valid_i),
        .hit_i       (live_hit),
        .data_i      (rd_data),
        .rsp_valid_o (rsp_valid_o),
        .rsp_hit_o   (rsp_hit_o),
        .rsp_data_o  (rsp_data_o)
    );

endmodule

// File: rtl/mlc_chk.sv
module mlc_chk #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_i,
    input logic               probe_valid_i,
    input logic               rsp_valid_o,
    input logic               rsp_hit_o,
    input logic [LINE_W-1:0]  rsp_data_o,
    input logic [ENTRIES-1:0] vld
);

    // R2
    probe_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid_i |=> rsp_valid_o);

    // R2
    quiet_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_valid_i |=> !rsp_valid_o);

    // R10
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit_o |-> rsp_valid_o);

    // R4
    miss_zero_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_hit_o) |-> (rsp_data_o == '0));

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (vld == '0));

    // R8
    flush_probe_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && probe_valid_i) |=> !rsp_hit_o);

endmodule

bind miss_line_cache mlc_chk #(
    .ENTRIES(ENTRIES), .LINE_W(LINE_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .probe_valid_i (probe_valid_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_hit_o     (rsp_hit_o),
    .rsp_data_o    (rsp_data_o),
    .vld           (vld_vec)
);

// File: tb/miss_line_cache_tb_top.sv
`timescale 1ns/1ps
module miss_line_cache_tb_top;

    localparam int N  = 4;
    localparam int AW = 28;
    localparam int LW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic          probe_valid_i = 1'b0;
    logic [AW-1:0] probe_addr_i = '0;
    logic          rsp_valid_o;
    logic          rsp_hit_o;
    logic [LW-1:0] rsp_data_o;
    logic          fill_valid_i = 1'b0;
    logic [AW-1:0] fill_addr_i = '0;
    logic [LW-1:0] fill_data_i = '0;

    int checks = 0;
    int errors = 0;
    logic          got_hit;
    logic [LW-1:0] got_data;

    always #5 clk = ~clk;

    miss_line_cache #(.ENTRIES(N), .ADDR_W(AW), .LINE_W(LW)) dut_i (.*);

    function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a, input logic [7:0] salt);
        return {4{32'(a) ^ {salt, 24'h5A_C300}}};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fill(input logic [AW-1:0] a, input logic [LW-1:0] d);
        @(negedge clk);
        fill_valid_i = 1'b1; fill_addr_i = a; fill_data_i = d;
        @(negedge clk);
        fill_valid_i = 1'b0;
    endtask

    task automatic probe(input logic [AW-1:0] a);
        @(negedge clk);
        probe_valid_i = 1'b1; probe_addr_i = a;
        @(negedge clk);
        probe_valid_i = 1'b0;
        got_hit = rsp_hit_o; got_data = rsp_data_o;
    endtask

    task automatic expect_hit(input logic [AW-1:0] a, input logic [LW-1:0] d, input string req);
        probe(a);
        chk(got_hit === 1'b1, req, LW'(got_hit), 1);
        chk(got_data === d, req, got_data, d);
    endtask

    task automatic expect_miss(input logic [AW-1:0] a, input string req);
        probe(a);
        chk(got_hit === 1'b0, req, LW'(got_hit), 0);
        chk(got_data === '0, req, got_data, 0);
    endtask

    task automatic fill_four();
        for (int i = 0; i < N; i++) fill(AW'(16'h100 + i), line_of(AW'(16'h100 + i), 8'h11));
    endtask

    task automatic t_reset();
        do_reset();
        chk(rsp_valid_o === 1'b0, "R1 valid", LW'(rsp_valid_o), 0);
        expect_miss(AW'(0), "R1 empty");
        expect_miss(AW'(16'h100), "R1 empty");
    endtask

    task automatic t_timing();
        do_reset();
        @(negedge clk);
        probe_valid_i = 1'b1; probe_addr_i = AW'(7);
        @(negedge clk);
        probe_valid_i = 1'b0;
        chk(rsp_valid_o === 1'b1, "R2 answer", LW'(rsp_valid_o), 1);
        chk(rsp_hit_o === 1'b0, "R10 miss flag", LW'(rsp_hit_o), 0);
        @(negedge clk);
        chk(rsp_valid_o === 1'b0, "R2 quiet", LW'(rsp_valid_o), 0);
        chk(rsp_hit_o === 1'b0, "R10 quiet", LW'(rsp_hit_o), 0);
    endtask

    task automatic t_fill_hit();
        do_reset();
        fill_four();
        for (int i = N - 1; i >= 0; i--)
            expect_hit(AW'(16'h100 + i), line_of(AW'(16'h100 + i), 8'h11), "R3 R5 hit");
        expect_miss(AW'(16'h200), "R4 miss");
    endtask

    task automatic t_lru();
        do_reset();
        fill_four();
        expect_hit(AW'(16'h100), line_of(AW'(16'h100), 8'h11), "R6 touch");
        fill(AW'(16'h300), line_of(AW'(16'h300), 8'h22));
        expect_miss(AW'(16'h101), "R6 evict");
        expect_hit(AW'(16'h100), line_of(AW'(16'h100), 8'h11), "R6 keep");
        expect_hit(AW'(16'h102), line_of(AW'(16'h102), 8'h11), "R6 keep");
        expect_hit(AW'(16'h300), line_of(AW'(16'h300), 8'h22), "R6 new");
    endtask

    task automatic t_update();
        do_reset();
        fill_four();
        fill(AW'(16'h100), line_of(AW'(16'h100), 8'h33));
        fill(AW'(16'h301), line_of(AW'(16'h301), 8'h22));
        expect_miss(AW'(16'h101), "R7 evict");
        expect_hit(AW'(16'h100), line_of(AW'(16'h100), 8'h33), "R7 updated");
        expect_hit(AW'(16'h103), line_of(AW'(16'h103), 8'h11), "R7 other");
    endtask

    task automatic t_flush();
        do_reset();
        fill_four();
        @(negedge clk);
        flush_i = 1'b1; probe_valid_i = 1'b1; probe_addr_i = AW'(16'h102);
        fill_valid_i = 1'b1; fill_addr_i = AW'(16'h400); fill_data_i = line_of(AW'(16'h400), 8'h44);
        @(negedge clk);
        flush_i = 1'b0; probe_valid_i = 1'b0; fill_valid_i = 1'b0;
        chk(rsp_hit_o === 1'b0, "R8 probe in flush", LW'(rsp_hit_o), 0);
        expect_miss(AW'(16'h102), "R8 cleared");
        expect_miss(AW'(16'h400), "R8 fill dropped");
    endtask

    task automatic t_same_cycle();
        do_reset();
        fill_four();
        @(negedge clk);
        probe_valid_i = 1'b1; probe_addr_i = AW'(16'h100);
        fill_valid_i = 1'b1; fill_addr_i = AW'(16'h500); fill_data_i = line_of(AW'(16'h500), 8'h55);
        @(negedge clk);
        probe_valid_i = 1'b0; fill_valid_i = 1'b0;
        chk(rsp_hit_o === 1'b1, "R9 hit", LW'(rsp_hit_o), 1);
        chk(rsp_data_o === line_of(AW'(16'h100), 8'h11), "R9 data", rsp_data_o, line_of(AW'(16'h100), 8'h11));
        expect_miss(AW'(16'h101), "R9 victim");
        expect_hit(AW'(16'h100), line_of(AW'(16'h100), 8'h11), "R9 survivor");
        expect_hit(AW'(16'h500), line_of(AW'(16'h500), 8'h55), "R9 new");
        // same address probed and refilled together
        @(negedge clk);
        probe_valid_i = 1'b1; probe_addr_i = AW'(16'h103);
        fill_valid_i = 1'b1; fill_addr_i = AW'(16'h103); fill_data_i = line_of(AW'(16'h103), 8'h66);
        @(negedge clk);
        probe_valid_i = 1'b0; fill_valid_i = 1'b0;
        chk(rsp_data_o === line_of(AW'(16'h103), 8'h11), "R9 old line", rsp_data_o, line_of(AW'(16'h103), 8'h11));
        expect_hit(AW'(16'h103), line_of(AW'(16'h103), 8'h66), "R9 R7 new line");
        expect_hit(AW'(16'h102), line_of(AW'(16'h102), 8'h11), "R9 R7 no dup");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_timing();
        t_fill_hit();
        t_lru();
        t_update();
        t_flush();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule